// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Pacer

This block sits beside a DRAM controller and decides when refresh work must happen. After reset it holds everything quiet for a power-up settling pause. It then requests a short burst of initialization refreshes, and only after the last of these is acknowledged does it declare the memory ready. From that point it raises a refresh request at a steady pace, so that the full row count is covered within each retention window. The controller answers each refresh it performs with a one-cycle acknowledge.

Requests that the controller cannot serve at once are counted in a small saturating backlog. A busy spell therefore delays refreshes without dropping them. If the backlog fills, a sticky error flag records that the refresh schedule can no longer be met. Every cycle count is derived from a clock-frequency parameter when the design is elaborated. A mode parameter picks the long retention window used by low-power parts; by default the standard window is used.

Top module: `dram_refresh_pacer`

## Requirements
- R1: While `rst_n` is low, `refresh_req`, `init_done` and `backlog_err` are all 0, and the backlog is emptied.
- R2: After reset is released, `refresh_req` and `init_done` stay 0 for the first PAUSE_CYC-1 rising edges, where PAUSE_CYC is 200 us of clock cycles (10000 at 50 MHz). `refresh_req` is 1 after edge PAUSE_CYC. A `refresh_ack` during the pause has no effect.
- R3: During initialization, `refresh_req` is held at 1. Each rising edge with `refresh_ack` at 1 counts one refresh. `init_done` stays 0 until the eighth counted acknowledge. It becomes 1 at that same edge, with `refresh_req` returning to 0.
- R4: In standard mode, a refresh is owed every (CLK_HZ/1000)*32/2048 cycles (781 at 50 MHz), measured from the edge at which `init_done` rises.
- R5: In low-power mode, a refresh is owed every (CLK_HZ/1000)*128/2048 cycles (3125 at 50 MHz).
- R6: After initialization, the backlog rises by one for each owed refresh and falls by one for each acknowledge. An owed refresh and an acknowledge at the same edge leave it unchanged. `refresh_req` is 1 exactly while the backlog is nonzero.
- R7: An acknowledge while `refresh_req` is 0 is ignored. The backlog never goes below zero.
- R8: The backlog saturates at 2^BACKLOG_W-1 (7 by default). Refreshes owed while it is full are lost, so exactly 7 acknowledges empty a full backlog.
- R9: `backlog_err` becomes 1 at the edge where the backlog reaches its maximum. It then stays 1 until reset.
- R10: Once `init_done` is 1, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_ack | input | 1 | One pulse per refresh the controller has completed |
| refresh_req | output | 1 | Refresh work is pending |
| init_done | output | 1 | Power-up sequence complete, normal accesses allowed |
| backlog_err | output | 1 | Sticky flag: backlog reached saturation |

## Verification
A wrong phase or timer value shows at the ports almost at once. The rise of `refresh_req` that ends the pause moves by the size of the error. A counting slip in initialization moves the `init_done` edge to a different acknowledge. A wrong backlog is hidden while `refresh_req` is high, but it shows the moment the bench drains it: `refresh_req` falls one acknowledge early or late. The saturation point appears as the cycle at which `backlog_err` rises. The bench therefore compares every output against its model on every cycle. It also counts drain acknowledges exactly, so a miscount is caught at the first port transition it shifts.

// File: rtl/dram_refresh_pacer.sv
module dram_refresh_pacer #(
  parameter int CLK_HZ         = 50_000_000,
  parameter bit LOW_POWER      = 1'b0,
  parameter int PAUSE_US       = 200,
  parameter int INIT_REFRESHES = 8,
  parameter int ROW_COUNT      = 2048,
  parameter int STD_WINDOW_MS  = 32,
  parameter int LP_WINDOW_MS   = 128,
  parameter int BACKLOG_W      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_ack,
  output logic refresh_req,
  output logic init_done,
  output logic backlog_err
);

  localparam int PAUSE_CYC    = (CLK_HZ / 1_000_000) * PAUSE_US;
  localparam int WINDOW_MS    = LOW_POWER ? LP_WINDOW_MS : STD_WINDOW_MS;
  localparam int INTERVAL_CYC = (CLK_HZ / 1000) * WINDOW_MS / ROW_COUNT;
  localparam int TMR_MAX      = (PAUSE_CYC > INTERVAL_CYC) ? PAUSE_CYC : INTERVAL_CYC;
  localparam int TMR_W        = $clog2(TMR_MAX + 1);
  localparam int INIT_W       = $clog2(INIT_REFRESHES + 1);
  localparam logic [BACKLOG_W-1:0] BL_FULL = {BACKLOG_W{1'b1}};

  typedef enum logic [1:0] {ST_PAUSE, ST_INIT, ST_RUN} phase_t;

  phase_t               phase;
  logic [TMR_W-1:0]     timer;
  logic [INIT_W-1:0]    init_cnt;
  logic [BACKLOG_W-1:0] backlog, backlog_nxt;

  wire pause_end = (phase == ST_PAUSE) && (timer == TMR_W'(PAUSE_CYC - 1));
  wire tick      = (phase == ST_RUN) && (timer == TMR_W'(INTERVAL_CYC - 1));
  wire init_last = (phase == ST_INIT) && refresh_ack &&
                   (init_cnt == INIT_W'(INIT_REFRESHES - 1));
  wire ack_take  = refresh_ack && (backlog != '0);

  assign refresh_req = (phase == ST_INIT) || ((phase == ST_RUN) && (backlog != '0));
  assign init_done   = (phase == ST_RUN);

  always_comb begin
    backlog_nxt = backlog;
    if (tick && !ack_take && backlog != BL_FULL) backlog_nxt = backlog + 1'b1;
    else if (!tick && ack_take)                  backlog_nxt = backlog - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= ST_PAUSE;
      timer <= '0;
    end else begin
      case (phase)
        ST_PAUSE: begin
          timer <= pause_end ? '0 : timer + TMR_W'(1);
          if (pause_end) phase <= ST_INIT;
        end
        ST_INIT: begin
          timer <= '0;
          if (init_last) phase <= ST_RUN;
        end
        default: timer <= tick ? '0 : timer + TMR_W'(1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            init_cnt <= '0;
    else if (phase == ST_INIT && refresh_ack) init_cnt <= init_cnt + INIT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      backlog     <= '0;
      backlog_err <= 1'b0;
    end else if (phase == ST_RUN) begin
      backlog <= backlog_nxt;
      if (backlog_nxt == BL_FULL) backlog_err <= 1'b1;
    end
  end

  AST_QUIET_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_PAUSE && !pause_end) |=> (!refresh_req && !init_done)); // R2
  AST_DONE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(refresh_ack)); // R3
  AST_TICK_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !refresh_ack) |=> refresh_req); // R4
  AST_BACKLOG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (backlog != $past(backlog)) |->
      (backlog == $past(backlog) + 1'b1 || backlog == $past(backlog) - 1'b1)); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && backlog == BL_FULL && !refresh_ack) |=> (backlog == BL_FULL)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    backlog_err |=> backlog_err); // R9
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R10

endmodule

// File: tb/test_dram_refresh_pacer.sv
module test_dram_refresh_pacer;
  localparam int PAUSE = 10000;
  localparam int IV0   = 781;
  localparam int IV1   = 3125;

  logic clk = 1'b0, rst_n = 1'b0, ack = 1'b0;
  logic req0, done0, err0, req1, done1, err1;
  always #10 clk = ~clk;

  dram_refresh_pacer i_dram_refresh_pacer (
    .clk(clk), .rst_n(rst_n), .refresh_ack(ack),
    .refresh_req(req0), .init_done(done0), .backlog_err(err0));
  dram_refresh_pacer #(.LOW_POWER(1'b1)) i_dram_refresh_pacer_lp (
    .clk(clk), .rst_n(rst_n), .refresh_ack(ack),
    .refresh_req(req1), .init_done(done1), .backlog_err(err1));

  int checks = 0, fails = 0, cyc = 0;
  int m_ph[2], m_t[2], m_acks[2], m_bl[2];
  bit m_err[2];
  int last_rise[2], gap[2];
  bit prev_req[2];
  int ivs[2] = '{IV0, IV1};

  initial for (int k = 0; k < 2; k++) begin
    m_ph[k] = 0; m_t[k] = 0; m_acks[k] = 0; m_bl[k] = 0; m_err[k] = 0;
    last_rise[k] = -1; gap[k] = 0; prev_req[k] = 0;
  end

  always @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_ph[k] = 0; m_t[k] = 0; m_acks[k] = 0; m_bl[k] = 0; m_err[k] = 0;
      end else if (m_ph[k] == 0) begin
        if (m_t[k] == PAUSE - 1) begin m_ph[k] = 1; m_t[k] = 0; end
        else m_t[k]++;
      end else if (m_ph[k] == 1) begin
        if (ack) m_acks[k]++;
        if (m_acks[k] == 8) begin m_ph[k] = 2; m_t[k] = 0; end
      end else begin
        automatic bit tk = (m_t[k] == ivs[k] - 1);
        automatic int d = m_bl[k];
        m_t[k] = tk ? 0 : m_t[k] + 1;
        if (tk) d++;
        if (ack && m_bl[k] > 0) d--;
        if (d > 7) d = 7;
        m_bl[k] = d;
        if (m_bl[k] == 7) m_err[k] = 1;
      end
    end
  end

  function automatic string tag_req(int k);
    if (!rst_n) return "R1";
    if (m_ph[k] == 0) return "R2";
    if (m_ph[k] == 1) return "R3";
    return (m_bl[k] == 7) ? "R8" : "R6";
  endfunction

  task automatic chk(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic r[2], d[2], e[2];
    r[0] = req0; d[0] = done0; e[0] = err0;
    r[1] = req1; d[1] = done1; e[1] = err1;
    cyc++;
    for (int k = 0; k < 2; k++) begin
      chk(tag_req(k), r[k], (m_ph[k] == 1) || (m_ph[k] == 2 && m_bl[k] > 0), "refresh_req");
      chk(!rst_n ? "R1" : (m_ph[k] == 2 ? "R10" : "R3"), d[k], m_ph[k] == 2, "init_done");
      chk(!rst_n ? "R1" : "R9", e[k], m_err[k], "backlog_err");
      if (r[k] && !prev_req[k] && d[k]) begin
        if (last_rise[k] >= 0) gap[k] = cyc - last_rise[k];
        last_rise[k] = cyc;
      end
      prev_req[k] = r[k];
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) step();
    chk("R1", req0, 1'b0, "reset req");
    chk("R1", done0, 1'b0, "reset done");
    chk("R1", err0, 1'b0, "reset err");
    rst_n = 1'b1;
    repeat (100) step();
    ack = 1'b1; step(); ack = 1'b0;
    repeat (PAUSE - 1 - 101) step();
    chk("R2", req0, 1'b0, "req before pause end");
    chk("R2", done0, 1'b0, "done in pause");
    step();
    chk("R2", req0, 1'b1, "req at pause end");
    chk("R5", req1, 1'b1, "lp req at pause end");
    for (int i = 0; i < 8; i++) begin
      ack = 1'b1; step(); ack = 1'b0;
      chk("R3", done0, i == 7, "done after init ack");
      chk("R3", req0, i != 7, "req during init");
      step();
    end
    ack = 1'b1;
    repeat (2 * IV1 + 200) step();
    ack = 1'b0;
    checks++;
    if (gap[0] != IV0) begin fails++; $display("FAIL R4 interval: actual %0d expected %0d", gap[0], IV0); end
    checks++;
    if (gap[1] != IV1) begin fails++; $display("FAIL R5 interval: actual %0d expected %0d", gap[1], IV1); end
    repeat (9 * IV0) step();
    chk("R9", err0, 1'b1, "err after saturation");
    chk("R9", err1, 1'b0, "lp err not saturated");
    while (m_t[0] != 10) step();
    for (int i = 1; i <= 7; i++) begin
      ack = 1'b1; step(); ack = 1'b0;
      chk("R8", req0, i < 7, "req while draining full backlog");
      step();
    end
    repeat (3) begin ack = 1'b1; step(); ack = 1'b0; step(); end
    chk("R7", req0, 1'b0, "req after acks with empty backlog");
    while (!req0) step();
    ack = 1'b1; step(); ack = 1'b0;
    chk("R7", req0, 1'b0, "single ack clears one owed refresh");
    chk("R9", err0, 1'b1, "err sticky");
    chk("R10", done0, 1'b1, "done held");
    step();
    rst_n = 1'b0;
    step();
    chk("R1", err0, 1'b0, "err cleared by reset");
    chk("R1", done0, 1'b0, "done cleared by reset");
    chk("R1", req0, 1'b0, "req cleared by reset");
    finish_run();
  end
endmodule